// File: doc/BRIEF.md
# Three-Segment Multiply-Accumulate Stream Pipeline

This block computes `a * b + c` for a stream of unsigned operand triples. It has three clocked segments. The first segment captures the two factors. It also captures the addend in a one-cycle alignment register, so a producer supplies all three operands together. The second segment forms the product and moves the aligned addend beside it. The third segment adds the two and registers the result. Each segment takes one clock, so one new triple can enter on every cycle and each result leaves a fixed number of cycles later.

The stream interface carries a valid strobe on each side and has no ready signal. The block never applies back-pressure: every cycle in which `in_valid` is high consumes a triple, and the consumer must take every cycle in which `out_valid` is high. Cycles with `in_valid` low are bubbles. A bubble travels down the pipeline and never raises the output strobe.

A run counter measures how many clock edges a burst keeps the pipeline working. For a continuous burst of n triples through the three segments it settles at n + 2, which is the k + n - 1 figure for k = 3.

Top module: `mac3_pipe`

## Requirements
- R1: A triple accepted in cycle t (in_valid high at the rising edge that ends cycle t) raises out_valid for exactly one cycle, in cycle t+3.
- R2: When out_valid is high, out_result equals in_a * in_b + in_c. All three operands are taken from the single cycle in which the triple was accepted.
- R3: A cycle with in_valid low produces no out_valid strobe. While out_valid is low, out_result keeps the value of the last result.
- R4: While rst is high at a rising edge, out_valid and out_result are cleared to 0. Triples that are in flight at that edge never produce a strobe.
- R5: Triples accepted on consecutive cycles produce strobes on consecutive cycles, in the order they were accepted.
- R6: span_cycles counts the rising edges at which a triple enters or at least one triple sits in the first or second segment. A triple that enters while both of those segments are empty restarts the count at 1. A continuous burst of n triples therefore ends with a count of n + 2.
- R7: At edges with no entering triple and nothing in the first two segments, span_cycles holds its value.
- R8: With all operands at 2^W-1, the result is (2^W-1)^2 + (2^W-1) with no truncation: 65280 for W = 8.
- R9: While rst is high at a rising edge, span_cycles is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand triple present this cycle |
| in_a | input | W | First factor, unsigned |
| in_b | input | W | Second factor, unsigned |
| in_c | input | W | Addend, unsigned, same cycle as factors |
| out_valid | output | 1 | Result strobe |
| out_result | output | 2W+1 | a*b+c of the strobed triple |
| span_cycles | output | CNT_W | Clock edges spent on the current or last run |

## Verification
The bench goes after the alignment of the addend with its product. A design that passes the addend through one register too few or too many adds the neighbouring triple's addend, and the back-to-back table rows catch it. Single bubbles between inputs check that a stale segment never raises the strobe and that the held result does not drift. A design that lets a bubble through shows an extra strobe or a changed value. For the run counter, the bench checks the n + 2 total on a full burst, the continued count across single bubbles and the restart after a drain. An off-by-one in where the count starts or stops shows up as 10 or 12 instead of 11. A reset with a triple in flight checks that the triple is discarded. A design that kept its valid bit would emit a strobe after the reset.

// File: rtl/mac3_pkg.sv
package mac3_pkg;
  localparam int unsigned MAC3_SEGMENTS = 3;

  function automatic int unsigned mac3_res_width(input int unsigned w);
    return 2 * w + 1;
  endfunction
endpackage

// File: rtl/mac3_operand_stage.sv
module mac3_operand_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_c,
  output logic         s1_valid,
  output logic [W-1:0] s1_a,
  output logic [W-1:0] s1_b,
  output logic [W-1:0] s1_c_align
);
  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= in_valid;
  end

  // operand registers load only on real triples
  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_a       <= in_a;
      s1_b       <= in_b;
      s1_c_align <= in_c;
    end
  end
endmodule

// File: rtl/mac3_product_stage.sv
module mac3_product_stage #(
  parameter int unsigned W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           s1_valid,
  input  logic [W-1:0]   s1_a,
  input  logic [W-1:0]   s1_b,
  input  logic [W-1:0]   s1_c_align,
  output logic           s2_valid,
  output logic [2*W-1:0] s2_prod,
  output logic [W-1:0]   s2_addend
);
  localparam int unsigned PW = 2 * W;

  always_ff @(posedge clk) begin
    if (rst) s2_valid <= 1'b0;
    else     s2_valid <= s1_valid;
  end

  always_ff @(posedge clk) begin
    if (s1_valid) begin
      s2_prod   <= PW'(s1_a) * PW'(s1_b);
      s2_addend <= s1_c_align;
    end
  end
endmodule

// File: rtl/mac3_sum_stage.sv
module mac3_sum_stage #(
  parameter int unsigned W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           s2_valid,
  input  logic [2*W-1:0] s2_prod,
  input  logic [W-1:0]   s2_addend,
  output logic           s3_valid,
  output logic [2*W:0]   s3_sum
);
  localparam int unsigned RW = 2 * W + 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s3_valid <= 1'b0;
      s3_sum   <= '0;
    end else begin
      s3_valid <= s2_valid;
      if (s2_valid) s3_sum <= RW'(s2_prod) + RW'(s2_addend);
    end
  end
endmodule

// File: rtl/mac3_span_counter.sv
module mac3_span_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             entering,
  input  logic             pending,
  output logic [CNT_W-1:0] span
);
  localparam logic [CNT_W-1:0] SPAN_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst)                            span <= '0;
    else if (pending && span != SPAN_MAX) span <= span + 1'b1;
    else if (entering && !pending)      span <= CNT_W'(1);
  end

  p_restart_r6: assert property (@(posedge clk) disable iff (rst)
    (entering && !pending) |=> span == CNT_W'(1));
  p_step_r6: assert property (@(posedge clk) disable iff (rst)
    (pending && span != SPAN_MAX) |=> span == $past(span) + 1'b1);
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!entering && !pending) |=> $stable(span));
endmodule

// File: rtl/mac3_pipe.sv
module mac3_pipe
  import mac3_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [W-1:0]              in_a,
  input  logic [W-1:0]              in_b,
  input  logic [W-1:0]              in_c,
  output logic                      out_valid,
  output logic [mac3_res_width(W)-1:0] out_result,
  output logic [CNT_W-1:0]          span_cycles
);
  localparam int unsigned RW = mac3_res_width(W);

  logic           s1_valid, s2_valid;
  logic [W-1:0]   s1_a, s1_b, s1_c_align, s2_addend;
  logic [2*W-1:0] s2_prod;

  mac3_operand_stage #(.W(W)) u_seg1 (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .s1_valid(s1_valid), .s1_a(s1_a), .s1_b(s1_b), .s1_c_align(s1_c_align)
  );

  mac3_product_stage #(.W(W)) u_seg2 (
    .clk(clk), .rst(rst), .s1_valid(s1_valid),
    .s1_a(s1_a), .s1_b(s1_b), .s1_c_align(s1_c_align),
    .s2_valid(s2_valid), .s2_prod(s2_prod), .s2_addend(s2_addend)
  );

  mac3_sum_stage #(.W(W)) u_seg3 (
    .clk(clk), .rst(rst), .s2_valid(s2_valid),
    .s2_prod(s2_prod), .s2_addend(s2_addend),
    .s3_valid(out_valid), .s3_sum(out_result)
  );

  mac3_span_counter #(.CNT_W(CNT_W)) u_span (
    .clk(clk), .rst(rst), .entering(in_valid),
    .pending(s1_valid | s2_valid), .span(span_cycles)
  );

  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##2 out_valid);
  p_no_phantom_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 3));
  p_value_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_result == (RW'($past(in_a, 3)) * RW'($past(in_b, 3))
                                 + RW'($past(in_c, 3))));
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_result));
endmodule

// File: tb/sim_mac3_pipe.sv
`timescale 1ns/1ps
module sim_mac3_pipe;
  localparam int W = 8;
  localparam int CNT_W = 16;
  localparam int RW = 2 * W + 1;
  localparam int NV = 9;
  localparam int TW = 3 * W + RW;

  // {a, b, c, expected}
  localparam logic [TW-1:0] VEC [NV] = '{
    {8'd3,   8'd4,   8'd5,   17'd17},
    {8'd0,   8'd0,   8'd0,   17'd0},
    {8'd255, 8'd255, 8'd255, 17'd65280},
    {8'd1,   8'd255, 8'd0,   17'd255},
    {8'd16,  8'd16,  8'd1,   17'd257},
    {8'd100, 8'd200, 8'd50,  17'd20050},
    {8'd255, 8'd0,   8'd255, 17'd255},
    {8'd7,   8'd9,   8'd200, 17'd263},
    {8'd128, 8'd2,   8'd255, 17'd511}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [W-1:0] in_a = '0, in_b = '0, in_c = '0;
  logic out_valid;
  logic [RW-1:0] out_result;
  logic [CNT_W-1:0] span_cycles;

  always #4 clk = ~clk;

  mac3_pipe #(.W(W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .out_valid(out_valid), .out_result(out_result), .span_cycles(span_cycles)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // output monitor
  logic [RW-1:0] got_val [64];
  int got_cyc [64];
  int n_out = 0;
  int hold_bad = 0;
  logic [RW-1:0] last_seen = '0;
  always @(negedge clk) begin
    if (out_valid && n_out < 64) begin
      got_val[n_out] = out_result;
      got_cyc[n_out] = cyc;
      n_out = n_out + 1;
    end
    if (!rst && !out_valid && out_result != last_seen) hold_bad = hold_bad + 1;
    last_seen = out_result;
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [W-1:0] a, b, c, output int at);
    @(negedge clk);
    in_valid = v; in_a = a; in_b = b; in_c = c;
    at = cyc;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  initial begin
    int in_cyc [NV];
    int base, t;
    repeat (3) @(negedge clk);
    chk("R4 reset out_valid", out_valid, 0);
    chk("R4 reset out_result", out_result, 0);
    chk("R9 reset span", span_cycles, 0);
    rst = 1'b0;
    idle(2);

    // table burst, back to back
    base = n_out;
    for (int i = 0; i < NV; i++)
      drive(1'b1, VEC[i][TW-1 -: W], VEC[i][TW-W-1 -: W], VEC[i][RW+W-1 -: W], in_cyc[i]);
    idle(6);
    chk("R5 burst strobe count", n_out - base, NV);
    for (int i = 0; i < NV; i++) begin
      chk($sformatf("R2 row %0d value", i), got_val[base+i], VEC[i][RW-1:0]);
      chk($sformatf("R1 row %0d latency", i), got_cyc[base+i] - in_cyc[i], 3);
      if (i > 0) chk($sformatf("R5 row %0d spacing", i), got_cyc[base+i] - got_cyc[base+i-1], 1);
    end
    chk("R8 max operands", got_val[base+2], 65280);
    chk("R6 burst span n+2", span_cycles, NV + 2);
    idle(5);
    chk("R7 span held when idle", span_cycles, NV + 2);

    // single bubbles between inputs
    base = n_out;
    drive(1'b1, 8'd2, 8'd3, 8'd1, t);
    idle(1);
    drive(1'b1, 8'd4, 8'd5, 8'd0, t);
    idle(1);
    drive(1'b1, 8'd1, 8'd1, 8'd1, t);
    idle(6);
    chk("R3 bubble strobe count", n_out - base, 3);
    chk("R3 bubble value 0", got_val[base], 7);
    chk("R3 bubble value 1", got_val[base+1], 20);
    chk("R3 bubble value 2", got_val[base+2], 2);
    chk("R3 bubble spacing", got_cyc[base+1] - got_cyc[base], 2);
    chk("R6 span across bubbles", span_cycles, 7);

    // restart after drain
    base = n_out;
    drive(1'b1, 8'd10, 8'd10, 8'd10, t);
    idle(6);
    chk("R6 restart span", span_cycles, 3);
    chk("R2 single value", got_val[base], 110);
    chk("R1 single latency", got_cyc[base] - t, 3);
    chk("R3 result held between strobes", hold_bad, 0);

    // reset with a triple in flight
    base = n_out;
    drive(1'b1, 8'd5, 8'd5, 8'd5, t);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    idle(6);
    chk("R4 in-flight discarded", n_out - base, 0);
    chk("R4 result cleared", out_result, 0);
    chk("R9 span cleared", span_cycles, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule